// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block sits between a simple synchronous request port and an asynchronous fast-page-mode DRAM of 2M bytes. Each request carries a 21-bit word address, a write flag and a byte of write data. The controller puts the row and then the column on an 11-bit multiplexed address bus and sequences the row strobe, column strobe, write enable and output enable. Every delay is a whole number of clock cycles set by a parameter.

The row of the last access stays open. A later request to that row runs as a column-strobe-only page cycle. A request to another row, the approach of the longest allowed row-strobe low time, or a refresh request from an external scheduler closes the row. A closed row gets a full precharge before the next activation. Refresh uses the column-before-row method. The scheduler holds its request until the controller pulses completion.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe`, `rd_valid` and `req_ready` are low.
- R2: The request address splits as row = `req_addr[20:10]` and column = `req_addr[9:0]`. The row is on `dram_addr` when `dram_ras_n` falls and the column (zero in bit 10) is on it when `dram_cas_n` falls.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` is high with `dram_dq_out` equal to the request data from the cycle `dram_cas_n` falls until it rises.
- R4: A read returns the byte last written to that address on `rd_data`, with `rd_valid` high for exactly one cycle, while `dram_cas_n` is still low, one cycle before it rises.
- R5: A request to the currently open row starts a column-only cycle with no new falling edge of `dram_ras_n`.
- R6: A request to a different row closes the row, and `dram_ras_n` stays high at least `T_RP` cycles before any falling edge.
- R7: At least `T_RCD` cycles pass from the row-strobe fall to the column-strobe fall. The column strobe stays low at least `T_CAS` cycles, and between page cycles it stays high at least `T_CP` cycles.
- R8: `dram_ras_n` is never low for more than `RAS_MAX` consecutive cycles, even under a stream of same-row requests.
- R9: While `ref_req` is high, the controller closes any open row and then lowers `dram_cas_n` before `dram_ras_n`, with `dram_we_n` high. It holds the row strobe low `T_RAS` cycles and then pulses `ref_done` for one cycle.
- R10: `req_ready` is high only with the row closed and precharged or with the row open and the column strobe high, never while `ref_req` is high, and falls in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in the upper 11 bits |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Read data |
| ref_req | input | 1 | Refresh request, held until ref_done |
| ref_done | output | 1 | One-cycle refresh completion pulse |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
The properties assume that `ref_req`, once raised, stays high until `ref_done`. They also assume that `req_addr`, `req_write` and `req_wdata` are stable while `req_valid` waits for `req_ready`. The bench changes request fields only at falling clock edges and holds them until acceptance. It raises `ref_req` only between requests and drops it on the completion pulse. A behavioural memory model in the bench answers reads. It returns a byte only after a column-strobe fall with the output enable low. Read data therefore only matches if the strobes and the address arrive in the required order.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int ROW_W  = 11;
    localparam int COL_W  = 10;
    localparam int DATA_W = 8;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed and precharged
        ST_ACT,    // row strobe low, waiting row-to-column delay
        ST_CASL,   // column strobe low
        ST_CASH,   // column precharge after an access
        ST_OPEN,   // row open, waiting for work
        ST_PRE,    // row strobe high, precharging
        ST_REFC,   // refresh: column strobe low first
        ST_REFR    // refresh: row strobe low
    } fsm_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } acc_t;

    function automatic acc_t split_req(logic [ADDR_W-1:0] a, logic w, logic [DATA_W-1:0] d);
        acc_t r;
        r.row   = a[ADDR_W-1:COL_W];
        r.col   = a[COL_W-1:0];
        r.wr    = w;
        r.wdata = d;
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_down_timer.sv
module fpm_down_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)            cnt <= W'(RST_VAL);
        else if (load)      cnt <= val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fpm_ras_window.sv
module fpm_ras_window #(
    parameter int RAS_MAX = 20000,
    parameter int MARGIN  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_low,
    output logic near
);
    localparam int AW    = $clog2(RAS_MAX + 1);
    localparam int LIMIT = RAS_MAX - MARGIN;

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || !ras_low)        age <= '0;
        else if (age != AW'(RAS_MAX)) age <= age + 1'b1;
    end

    assign near = (age >= AW'(LIMIT));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int T_RP    = 3,
    parameter int T_RCD   = 2,
    parameter int T_CAS   = 4,
    parameter int T_CP    = 1,
    parameter int T_RAS   = 5,
    parameter int T_CSR   = 1,
    parameter int RAS_MAX = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_req,
    output logic              ref_done,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int TMAX   = max2(max2(max2(T_RP, T_RCD), max2(T_CAS, T_CP)), max2(T_RAS, T_CSR));
    localparam int TW     = $clog2(TMAX + 1);
    localparam int MARGIN = T_CAS + T_CP + 2;

    fsm_e            st, nx;
    acc_t            cur;
    logic            pend;
    logic            accept, hit, near, ras_low;
    logic [TW-1:0]   t_cnt;
    logic            t_zero;

    function automatic logic [TW-1:0] dur(fsm_e s);
        case (s)
            ST_ACT:  return TW'(T_RCD - 1);
            ST_CASL: return TW'(T_CAS - 1);
            ST_CASH: return TW'(T_CP - 1);
            ST_PRE:  return TW'(T_RP - 1);
            ST_REFC: return TW'(T_CSR - 1);
            ST_REFR: return TW'(T_RAS - 1);
            default: return '0;
        endcase
    endfunction

    fpm_down_timer #(.W(TW), .RST_VAL(T_RP - 1)) u_timer (
        .clk(clk), .rst(rst), .load(nx != st), .val(dur(nx)),
        .cnt(t_cnt), .zero(t_zero)
    );

    fpm_ras_window #(.RAS_MAX(RAS_MAX), .MARGIN(MARGIN)) u_window (
        .clk(clk), .rst(rst), .ras_low(ras_low), .near(near)
    );

    assign hit       = (req_addr[ADDR_W-1:COL_W] == cur.row);
    assign req_ready = !ref_req && ((st == ST_IDLE) || (st == ST_OPEN && !near));
    assign accept    = req_valid && req_ready;

    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE: if (ref_req) nx = ST_REFC;
                     else if (accept) nx = ST_ACT;
            ST_ACT:  if (t_zero) nx = ST_CASL;
            ST_CASL: if (t_zero) nx = ST_CASH;
            ST_CASH: if (t_zero) nx = ST_OPEN;
            ST_OPEN: if (ref_req || near) nx = ST_PRE;
                     else if (accept) nx = hit ? ST_CASL : ST_PRE;
            ST_PRE:  if (t_zero) nx = pend ? ST_ACT : (ref_req ? ST_REFC : ST_IDLE);
            ST_REFC: if (t_zero) nx = ST_REFR;
            ST_REFR: if (t_zero) nx = ST_PRE;
            default: nx = ST_PRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_PRE;
            cur      <= '0;
            pend     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            ref_done <= 1'b0;
        end else begin
            st <= nx;
            if (accept) cur <= split_req(req_addr, req_write, req_wdata);
            if (accept && st == ST_OPEN && !hit) pend <= 1'b1;
            else if (st == ST_PRE && t_zero)     pend <= 1'b0;
            rd_valid <= (st == ST_CASL) && (t_cnt == TW'(1)) && !cur.wr;
            if ((st == ST_CASL) && (t_cnt == TW'(1)) && !cur.wr) rd_data <= dram_dq_in;
            ref_done <= (st == ST_REFR) && t_zero;
        end
    end

    // Pin decode from the registered state.
    assign ras_low     = (st == ST_ACT) || (st == ST_CASL) || (st == ST_CASH) ||
                         (st == ST_OPEN) || (st == ST_REFR);
    assign dram_ras_n  = !ras_low;
    assign dram_cas_n  = !((st == ST_CASL) || (st == ST_REFC) || (st == ST_REFR));
    assign dram_we_n   = !((st == ST_CASL) && cur.wr);
    assign dram_oe_n   = !((st == ST_CASL) && !cur.wr);
    assign dram_dq_oe  = (st == ST_CASL) && cur.wr;
    assign dram_dq_out = cur.wdata;

    // Row stays on the bus through the first activation cycle (row hold), column afterwards.
    always_comb begin
        if ((st == ST_ACT && t_cnt != TW'(T_RCD - 1)) || st == ST_CASL ||
            st == ST_CASH || st == ST_OPEN)
            dram_addr = BUS_W'(cur.col);
        else
            dram_addr = BUS_W'(cur.row);
    end
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter int T_RP    = 3,
    parameter int T_CAS   = 4,
    parameter int RAS_MAX = 20000
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rd_valid,
    input logic ref_done,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_dq_oe
);
    int hi_cnt, lo_cnt, cl_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
            cl_cnt <= 0;
        end else begin
            hi_cnt <= dram_ras_n ? ((hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt) : 0;
            lo_cnt <= dram_ras_n ? 0 : lo_cnt + 1;
            cl_cnt <= dram_cas_n ? 0 : cl_cnt + 1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (dram_ras_n && dram_cas_n && dram_we_n && !rd_valid && !dram_dq_oe));

    a_r3_write_data_driven: assert property (@(posedge clk) disable iff (rst)
        (!dram_cas_n && !dram_we_n) |-> dram_dq_oe);

    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r4_valid_in_cas: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!dram_cas_n && !dram_ras_n));

    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (hi_cnt >= T_RP));

    a_r7_cas_width: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_cas_n) |-> (cl_cnt >= T_CAS));

    a_r8_ras_limit: assert property (@(posedge clk) disable iff (rst)
        !dram_ras_n |-> (lo_cnt < RAS_MAX));

    a_r9_cbr_we_high: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> !ref_done);

    a_r10_ready_cas_high: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> dram_cas_n);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.T_RP(T_RP), .T_CAS(T_CAS), .RAS_MAX(RAS_MAX)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
    .ref_done(ref_done), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
    localparam int T_RP = 3, T_RCD = 2, T_CAS = 4, T_CP = 1, T_RAS = 5, RAS_MAX = 40;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, ref_req = 0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, dram_dq_in = '0;
    logic req_ready, rd_valid, ref_done, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0]  rd_data, dram_dq_out;
    logic [10:0] dram_addr;

    always #5 clk = ~clk;

    fpm_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                    .T_RAS(T_RAS), .RAS_MAX(RAS_MAX)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_done(ref_done),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference state: expected memory, outstanding addresses and read results.
    logic [7:0]  shadow [int];
    logic [7:0]  dram_mem [int];
    logic [20:0] addr_q [$];
    logic [7:0]  exp_q [$];

    // Behavioural memory and pin-timing observer, sampled at falling clock edges.
    logic prev_ras = 1, prev_cas = 1, prev_rdv = 0, had_cas = 0;
    int ras_hi_len = 0, ras_lo_len = 0, max_ras_lo = 0, since_ras = 0;
    int cas_lo_len = 0, cas_hi_len = 0, ras_falls = 0, refreshes = 0;
    logic [10:0] lat_row = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_active = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ras = 1; prev_cas = 1; prev_rdv = 0;
            ras_hi_len = 0; ras_lo_len = 0;
        end else begin
            // Row strobe falls
            if (prev_ras && !dram_ras_n) begin
                chk(ras_hi_len >= T_RP, "R6 precharge", ras_hi_len, T_RP);
                if (!dram_cas_n) begin
                    refreshes++;
                    chk(dram_we_n, "R9 we high in refresh", dram_we_n, 1);
                end else begin
                    ras_falls++;
                    lat_row = dram_addr;
                end
                had_cas = 0;
            end
            // Column strobe falls during an open row
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                logic [20:0] ea;
                chk(since_ras >= T_RCD, "R7 ras to cas", since_ras, T_RCD);
                if (had_cas) chk(cas_hi_len >= T_CP, "R7 cas precharge", cas_hi_len, T_CP);
                had_cas = 1;
                ea = (addr_q.size() > 0) ? addr_q.pop_front() : 21'h1FFFFF;
                chk({lat_row, dram_addr[9:0]} == ea && dram_addr[10] == 1'b0,
                    "R2 address mux", {lat_row, dram_addr}, ea);
                if (!dram_we_n) begin
                    chk(dram_dq_oe, "R3 data driven", dram_dq_oe, 1);
                    dram_mem[int'({lat_row, dram_addr[9:0]})] = dram_dq_out;
                    wr_data = dram_dq_out;
                    wr_active = 1;
                end else if (!dram_oe_n) begin
                    dram_dq_in = dram_mem.exists(int'({lat_row, dram_addr[9:0]})) ?
                                 dram_mem[int'({lat_row, dram_addr[9:0]})] : 8'hXX;
                end
            end
            if (wr_active && !dram_cas_n)
                chk(!dram_we_n && dram_dq_oe && dram_dq_out == wr_data, "R3 write held",
                    dram_dq_out, wr_data);
            // Column strobe rises
            if (!prev_cas && dram_cas_n) begin
                chk(cas_lo_len >= T_CAS, "R7 cas low width", cas_lo_len, T_CAS);
                wr_active = 0;
            end
            // Read strobe checks
            if (prev_rdv)
                chk(dram_cas_n && !rd_valid, "R4 valid one cycle before cas rise",
                    {dram_cas_n, rd_valid}, 2'b10);
            if (rd_valid) begin
                logic [7:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hEE;
                chk(rd_data == e, "R4 read data", rd_data, e);
                chk(!dram_cas_n, "R4 valid while cas low", dram_cas_n, 0);
            end
            if (req_ready) chk(dram_cas_n && !ref_req, "R10 ready state", dram_cas_n, 1);

            // Length trackers
            since_ras  = (prev_ras && !dram_ras_n) ? 1 : (!dram_ras_n ? since_ras + 1 : 0);
            ras_hi_len = dram_ras_n ? ras_hi_len + 1 : 0;
            ras_lo_len = dram_ras_n ? 0 : ras_lo_len + 1;
            if (ras_lo_len > max_ras_lo) max_ras_lo = ras_lo_len;
            cas_lo_len = dram_cas_n ? 0 : cas_lo_len + 1;
            cas_hi_len = dram_cas_n ? cas_hi_len + 1 : 0;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_rdv = rd_valid;
        end
    end

    function automatic logic [20:0] mk(int row, int col);
        return {11'(row), 10'(col)};
    endfunction

    task automatic do_req(bit wr, logic [20:0] a, logic [7:0] d);
        addr_q.push_back(a);
        if (wr) shadow[int'(a)] = d;
        else exp_q.push_back(shadow[int'(a)]);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
    endtask

    task automatic do_refresh();
        int r0;
        r0 = refreshes;
        @(negedge clk);
        ref_req = 1;
        @(negedge clk);
        chk(!req_ready, "R10 no ready during refresh request", req_ready, 0);
        while (!ref_done) @(negedge clk);
        ref_req = 0;
        chk(refreshes == r0 + 1, "R9 one refresh cycle", refreshes, r0 + 1);
        @(negedge clk);
        chk(!ref_done, "R9 done single pulse", ref_done, 0);
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() > 0 || addr_q.size() > 0) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int rf;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dram_dq_oe && !rd_valid && !req_ready, "R1 outputs idle in reset",
            {dram_dq_oe, rd_valid, req_ready}, 0);
        rst = 0;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !req_ready && !rd_valid, "R1 after reset",
            {dram_ras_n, dram_cas_n, req_ready, rd_valid}, 4'hC);

        // R5: two writes and two reads on one row, single activation
        rf = ras_falls;
        do_req(1, mk(5, 1), 8'hA5);
        do_req(1, mk(5, 2), 8'h3C);
        do_req(0, mk(5, 1), 0);
        do_req(0, mk(5, 2), 0);
        drain();
        chk(ras_falls == rf + 1, "R5 page hits without new activation", ras_falls, rf + 1);

        // R6: row miss forces a new activation
        rf = ras_falls;
        do_req(1, mk(9, 7), 8'h77);
        do_req(0, mk(9, 7), 0);
        do_req(0, mk(5, 2), 0);
        drain();
        chk(ras_falls == rf + 2, "R6 miss reactivates", ras_falls, rf + 2);

        // R2 boundary addresses
        do_req(1, mk(2047, 1023), 8'hFF);
        do_req(1, mk(0, 0), 8'h01);
        do_req(0, mk(2047, 1023), 0);
        do_req(0, mk(0, 0), 0);
        drain();

        // R9: refresh with a row open, then from idle, then access again
        do_req(0, mk(9, 7), 0);
        drain();
        do_refresh();
        do_refresh();
        rf = ras_falls;
        do_req(0, mk(9, 7), 0);
        drain();
        chk(ras_falls == rf + 1, "R9 row closed by refresh", ras_falls, rf + 1);

        // R8: stream of same-row requests must be cut by the row-strobe limit
        for (int i = 0; i < 8; i++) do_req(1, mk(12, i), 8'(8'h40 + i));
        rf = ras_falls;
        for (int k = 0; k < 30; k++) do_req(0, mk(12, k % 8), 0);
        drain();
        chk(max_ras_lo <= RAS_MAX, "R8 row strobe low limit", max_ras_lo, RAS_MAX);
        chk(ras_falls >= rf + 2, "R8 row closed and reopened", ras_falls, rf + 2);
        chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule